// File: doc/BRIEF.md
# Bus Data-Phase Handshake Monitor

This block is a passive checker for a parallel shared bus with active-low control lines. It watches five lines: the transaction-cycle line driven by the initiator, the initiator ready line, and the target's ready, stop and claim lines. It follows each data phase. A phase completes on an edge where the initiator is ready and the target is either ready or stopping. On each edge where both ready lines are asserted, the block emits a one-cycle transfer strobe. It emits a separate strobe when the final phase of a transaction completes.

The block enforces the rule that neither party may withdraw a commitment in the middle of a phase. Once the target asserts ready or stop, its claim, ready and stop lines must hold until the phase completes. Once the initiator asserts ready, that line must stay asserted until completion. The cycle line is dropped to announce the final phase, and it must not be raised again before that phase completes. Each breach sets its own sticky flag, and a synchronous clear input resets the flags. Wait states from either side are legal for any length of time.

Optional input register stages can be placed in front of the tracker to give timing relief. A parameter selects whether the error flags are sticky or pulse once per offending edge.

Top module: `hs_phase_monitor`

## Requirements
- R1: While `rst_n` is low, every output reads 0.
- R2: `xfer_o` is 1 in the cycle after an edge where `ini_rdy_l` and `tgt_rdy_l` were both sampled 0, and 0 after any other edge (all lines active low, 0 = asserted).
- R3: `last_o` is 1 in the cycle after an edge where `ini_rdy_l` was 0, `cyc_l` was 1, and `tgt_rdy_l` or `tgt_stop_l` was 0.
- R4: An edge where the target had asserted ready or stop at an earlier edge of the same, still open phase, and any of `tgt_claim_l`, `tgt_rdy_l`, `tgt_stop_l` differs from its previous sample, sets `err_tgt_o`.
- R5: An edge where `ini_rdy_l` is 1 after the initiator asserted it earlier in the same open phase sets `err_ini_o`.
- R6: An edge where `cyc_l` is 0 after an earlier edge of the same open phase saw `cyc_l` = 1 with `ini_rdy_l` = 0 sets `err_cyc_o`.
- R7: Any number of wait cycles, in which one side holds its ready line at 1 while the other lines stay steady, sets no flag.
- R8: With STICKY=1, a flag stays 1 until an edge that samples `clr_i` = 1. That edge clears all flags, even if a new breach occurs on the same edge.
- R9: The edge that completes a phase ends every commitment, so the lines may take any values on the next edge without a flag.
- R10: An edge with `cyc_l` = 1 and `ini_rdy_l` = 1 (idle bus) clears all phase tracking, so the following edge cannot raise a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the error flags |
| cyc_l | input | 1 | Transaction cycle line, active low |
| ini_rdy_l | input | 1 | Initiator ready, active low |
| tgt_rdy_l | input | 1 | Target ready, active low |
| tgt_stop_l | input | 1 | Target stop request, active low |
| tgt_claim_l | input | 1 | Target claim of the transaction, active low |
| xfer_o | output | 1 | One-cycle strobe for a data transfer |
| last_o | output | 1 | One-cycle strobe for completion of the final phase |
| err_tgt_o | output | 1 | Target changed its lines after committing |
| err_ini_o | output | 1 | Initiator withdrew ready after committing |
| err_cyc_o | output | 1 | Cycle line reasserted during the final phase |

## Verification
The bench builds the block with IN_STAGES=0 and STICKY=1, so every output follows its sampling edge by exactly one register. Expected values can therefore be computed one edge at a time. Under that configuration, the bench sweeps all 1024 pairs of a first and a second line pattern. Each pair starts from a cleared idle bus, which covers every combination of commitment, completion, idle and breach that two edges can produce. Directed sequences then add long waits from each side, back-to-back bursts, sticky hold, and a clear that lands on the same edge as a breach.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

   // Bus lines after inversion: 1 means asserted.
   typedef struct packed {
      logic cyc;
      logic ini;
      logic tgt;
      logic stp;
      logic clm;
   } hs_bus_t;

   typedef enum int unsigned {
      ERR_TGT = 0,
      ERR_INI = 1,
      ERR_CYC = 2
   } hs_err_e;

   localparam int unsigned NUM_ERR = 3;

   function automatic hs_bus_t hs_decode(input logic cyc_l, input logic ini_l,
                                         input logic tgt_l, input logic stp_l,
                                         input logic clm_l);
      hs_bus_t b;
      b.cyc = ~cyc_l;
      b.ini = ~ini_l;
      b.tgt = ~tgt_l;
      b.stp = ~stp_l;
      b.clm = ~clm_l;
      return b;
   endfunction

endpackage

// File: rtl/hs_sampler.sv
module hs_sampler
   import hs_mon_pkg::*;
#(
   parameter int unsigned STAGES = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  hs_bus_t raw_i,
   output hs_bus_t smp_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign smp_o = raw_i;
      end else begin : g_pipe
         hs_bus_t pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= raw_i;
               for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
            end
         end
         assign smp_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hs_phase_tracker.sv
module hs_phase_tracker
   import hs_mon_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  hs_bus_t            bus_i,
   output logic               xfer_o,
   output logic               done_last_o,
   output logic [NUM_ERR-1:0] viol_o
);

   logic tgt_cmt_q, ini_cmt_q, fin_pend_q;
   logic p_tgt_q, p_stp_q, p_clm_q;
   logic done, idle, tgt_moved;

   assign done      = bus_i.ini & (bus_i.tgt | bus_i.stp);
   assign idle      = ~bus_i.cyc & ~bus_i.ini;
   assign tgt_moved = (bus_i.tgt != p_tgt_q) | (bus_i.stp != p_stp_q) |
                      (bus_i.clm != p_clm_q);

   assign xfer_o      = bus_i.ini & bus_i.tgt;
   assign done_last_o = done & ~bus_i.cyc;

   always_comb begin
      viol_o          = '0;
      viol_o[ERR_TGT] = tgt_cmt_q & tgt_moved;
      viol_o[ERR_INI] = ini_cmt_q & ~bus_i.ini;
      viol_o[ERR_CYC] = fin_pend_q & bus_i.cyc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_cmt_q  <= 1'b0;
         ini_cmt_q  <= 1'b0;
         fin_pend_q <= 1'b0;
         p_tgt_q    <= 1'b0;
         p_stp_q    <= 1'b0;
         p_clm_q    <= 1'b0;
      end else begin
         p_tgt_q <= bus_i.tgt;
         p_stp_q <= bus_i.stp;
         p_clm_q <= bus_i.clm;
         if (idle || done) begin
            tgt_cmt_q  <= 1'b0;
            ini_cmt_q  <= 1'b0;
            fin_pend_q <= 1'b0;
         end else begin
            tgt_cmt_q  <= tgt_cmt_q | bus_i.tgt | bus_i.stp;
            ini_cmt_q  <= ini_cmt_q | bus_i.ini;
            fin_pend_q <= fin_pend_q | (~bus_i.cyc & bus_i.ini);
         end
      end
   end

endmodule

// File: rtl/hs_err_flags.sv
module hs_err_flags #(
   parameter int unsigned N      = 3,
   parameter bit          STICKY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [N-1:0] viol_i,
   output logic [N-1:0] flag_o
);

   generate
      if (STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_o <= '0;
            else if (clr_i) flag_o <= '0;
            else            flag_o <= flag_o | viol_i;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_o <= '0;
            else if (clr_i) flag_o <= '0;
            else            flag_o <= viol_i;
         end
      end
   endgenerate

endmodule

// File: rtl/hs_phase_monitor.sv
module hs_phase_monitor
   import hs_mon_pkg::*;
#(
   parameter int unsigned IN_STAGES = 0,
   parameter bit          STICKY    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic cyc_l,
   input  logic ini_rdy_l,
   input  logic tgt_rdy_l,
   input  logic tgt_stop_l,
   input  logic tgt_claim_l,
   output logic xfer_o,
   output logic last_o,
   output logic err_tgt_o,
   output logic err_ini_o,
   output logic err_cyc_o
);

   localparam int unsigned MAX_STAGES = 4;

   generate
      if (IN_STAGES > MAX_STAGES) begin : g_bad_stages
         $error("hs_phase_monitor: IN_STAGES above supported maximum");
      end
   endgenerate

   hs_bus_t            raw_bus, smp_bus;
   logic               xfer_c, last_c;
   logic [NUM_ERR-1:0] viol, flags;

   assign raw_bus = hs_decode(cyc_l, ini_rdy_l, tgt_rdy_l, tgt_stop_l, tgt_claim_l);

   hs_sampler #(.STAGES(IN_STAGES)) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_bus),
      .smp_o (smp_bus)
   );

   hs_phase_tracker u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_i       (smp_bus),
      .xfer_o      (xfer_c),
      .done_last_o (last_c),
      .viol_o      (viol)
   );

   hs_err_flags #(.N(NUM_ERR), .STICKY(STICKY)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .viol_i (viol),
      .flag_o (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_o <= 1'b0;
         last_o <= 1'b0;
      end else begin
         xfer_o <= xfer_c;
         last_o <= last_c;
      end
   end

   assign err_tgt_o = flags[ERR_TGT];
   assign err_ini_o = flags[ERR_INI];
   assign err_cyc_o = flags[ERR_CYC];

endmodule

// File: rtl/hs_phase_monitor_chk.sv
module hs_phase_monitor_chk #(
   parameter int unsigned IN_STAGES = 0,
   parameter bit          STICKY    = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic clr_i,
   input logic cyc_l,
   input logic ini_rdy_l,
   input logic tgt_rdy_l,
   input logic tgt_stop_l,
   input logic tgt_claim_l,
   input logic xfer_o,
   input logic last_o,
   input logic err_tgt_o,
   input logic err_ini_o,
   input logic err_cyc_o
);

   localparam int unsigned LAT = IN_STAGES + 1;
   localparam int unsigned AGE_MAX = LAT + 1;

   logic [3:0] age;
   logic       warm, warm2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    age <= '0;
      else if (age < 4'(AGE_MAX))    age <= age + 4'd1;
   end
   assign warm  = age >= 4'(LAT);
   assign warm2 = age >= 4'(AGE_MAX);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!xfer_o && !last_o && !err_tgt_o && !err_ini_o && !err_cyc_o));

   // R2
   xfer_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (xfer_o == $past(!ini_rdy_l && !tgt_rdy_l, LAT)));

   // R3
   last_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (last_o == $past(!ini_rdy_l && cyc_l && (!tgt_rdy_l || !tgt_stop_l), LAT)));

   // R4
   tgt_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm2 && $rose(err_tgt_o)) |->
         (($past(tgt_rdy_l, LAT) != $past(tgt_rdy_l, LAT + 1)) ||
          ($past(tgt_stop_l, LAT) != $past(tgt_stop_l, LAT + 1)) ||
          ($past(tgt_claim_l, LAT) != $past(tgt_claim_l, LAT + 1))));

   // R5
   ini_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $rose(err_ini_o)) |-> $past(ini_rdy_l, LAT));

   // R6
   cyc_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $rose(err_cyc_o)) |-> !$past(cyc_l, LAT));

   // R8
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!err_tgt_o && !err_ini_o && !err_cyc_o));

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (STICKY && !clr_i && err_ini_o) |=> err_ini_o);

endmodule

bind hs_phase_monitor hs_phase_monitor_chk #(.IN_STAGES(IN_STAGES), .STICKY(STICKY)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr_i       (clr_i),
   .cyc_l       (cyc_l),
   .ini_rdy_l   (ini_rdy_l),
   .tgt_rdy_l   (tgt_rdy_l),
   .tgt_stop_l  (tgt_stop_l),
   .tgt_claim_l (tgt_claim_l),
   .xfer_o      (xfer_o),
   .last_o      (last_o),
   .err_tgt_o   (err_tgt_o),
   .err_ini_o   (err_ini_o),
   .err_cyc_o   (err_cyc_o)
);

// File: tb/hs_phase_monitor_test.sv
`timescale 1ns/1ps
module hs_phase_monitor_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_i = 1'b0;
   logic cyc_l = 1'b1, ini_rdy_l = 1'b1, tgt_rdy_l = 1'b1, tgt_stop_l = 1'b1, tgt_claim_l = 1'b1;
   logic xfer_o, last_o, err_tgt_o, err_ini_o, err_cyc_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hs_phase_monitor #(.IN_STAGES(0), .STICKY(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
      .cyc_l(cyc_l), .ini_rdy_l(ini_rdy_l), .tgt_rdy_l(tgt_rdy_l),
      .tgt_stop_l(tgt_stop_l), .tgt_claim_l(tgt_claim_l),
      .xfer_o(xfer_o), .last_o(last_o), .err_tgt_o(err_tgt_o),
      .err_ini_o(err_ini_o), .err_cyc_o(err_cyc_o)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // pattern bits (1 = asserted): [4] cycle, [3] initiator ready, [2] target ready, [1] stop, [0] claim
   task automatic step(input logic [4:0] p, input logic clr);
      @(negedge clk);
      cyc_l       = ~p[4];
      ini_rdy_l   = ~p[3];
      tgt_rdy_l   = ~p[2];
      tgt_stop_l  = ~p[1];
      tgt_claim_l = ~p[0];
      clr_i       = clr;
      @(posedge clk);
      #1;
   endtask

   task automatic flags(input logic t, input logic i, input logic c, input string req);
      chk(err_tgt_o, t, {req, " tgt flag"});
      chk(err_ini_o, i, {req, " ini flag"});
      chk(err_cyc_o, c, {req, " cyc flag"});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      // R1 reset state
      chk(xfer_o, 1'b0, "R1 xfer");
      chk(last_o, 1'b0, "R1 last");
      flags(1'b0, 1'b0, 1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b1;

      // exhaustive two-edge sweep from a cleared idle bus
      for (int a = 0; a < 32; a++) begin
         for (int b = 0; b < 32; b++) begin
            logic [4:0] p, c;
            logic pdone, tc, ic, fc;
            p = 5'(a);
            c = 5'(b);
            step(5'b00000, 1'b1);
            step(p, 1'b0);
            // R10: coming from idle, nothing can be flagged yet
            flags(1'b0, 1'b0, 1'b0, "R10");
            pdone = p[3] & (p[2] | p[1]);
            tc = ~pdone & (p[2] | p[1]) & (p[4] | p[3]);
            ic = ~pdone & p[3];
            fc = ~pdone & p[3] & ~p[4];
            step(c, 1'b0);
            chk(xfer_o, c[3] & c[2], "R2");
            chk(last_o, c[3] & (c[2] | c[1]) & ~c[4], "R3");
            chk(err_tgt_o, tc & (c[2:0] != p[2:0]), "R4");
            chk(err_ini_o, ic & ~c[3], "R5");
            chk(err_cyc_o, fc & c[4], "R6");
         end
      end

      // R7 long waits: target waits, then initiator waits
      step(5'b00000, 1'b1);
      for (int k = 0; k < 7; k++) begin
         step(5'b11001, 1'b0);
         flags(1'b0, 1'b0, 1'b0, "R7 target wait");
      end
      step(5'b11101, 1'b0);
      chk(xfer_o, 1'b1, "R7 xfer after target wait");
      for (int k = 0; k < 7; k++) begin
         step(5'b10101, 1'b0);
         flags(1'b0, 1'b0, 1'b0, "R7 initiator wait");
         chk(xfer_o, 1'b0, "R7 no xfer while waiting");
      end
      step(5'b11101, 1'b0);
      chk(xfer_o, 1'b1, "R7 xfer after initiator wait");

      // R9 completed phase frees all lines on the next edge
      step(5'b10000, 1'b0);
      flags(1'b0, 1'b0, 1'b0, "R9 after completion");
      step(5'b11101, 1'b0);
      step(5'b10010, 1'b0);
      flags(1'b0, 1'b0, 1'b0, "R9 burst restart");

      // R8 sticky and clear priority
      step(5'b00000, 1'b1);
      step(5'b11001, 1'b0);
      step(5'b10001, 1'b0);
      chk(err_ini_o, 1'b1, "R5 withdraw");
      for (int k = 0; k < 4; k++) begin
         step(5'b00000, 1'b0);
         chk(err_ini_o, 1'b1, "R8 sticky hold");
      end
      step(5'b11001, 1'b0);
      step(5'b10001, 1'b1);
      chk(err_ini_o, 1'b0, "R8 clear beats breach");
      step(5'b00000, 1'b1);
      flags(1'b0, 1'b0, 1'b0, "R8 cleared");

      // R6 final phase, then cycle line back before completion
      step(5'b01001, 1'b0);
      step(5'b11001, 1'b0);
      chk(err_cyc_o, 1'b1, "R6 cycle reasserted");
      step(5'b00000, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule